// File: doc/BRIEF.md
# Attributed Character-Cell Text Generator

This block turns the pixel and line counts of a display timing generator into 4-bit colour indices for a palette. For each pixel it works out which character cell it falls in, fetches a 16-bit word for that cell from video RAM (character code in the low byte, attribute in the high byte), and reads that cell's glyph row from an internal writable font. The glyph byte is shifted out one pixel per clock, most significant bit first. Each pixel then gets a foreground or background index. Pixels outside the active area get a fixed border index.

The line width is 32, 40 or 44 cells, the cell height is 12 or 8 lines, and the active height is 192 or 240 lines. The font holds two banks of 256 glyphs, and one control bit picks the bank. With attributes enabled, the foreground follows the three teletext-style colour bits of each cell over a black background. With attributes off, text is white on black. A small write port sets the screen start word address and the control word, and a second write port loads the font. Sync generation and analogue output are handled elsewhere.

Top module: `atg_text_gen`

## Requirements
- R1: While reset is high and on the first edge after it, `pix_idx` is the border index 8. The control word resets to 0 (32 cells, 12-line cells, 192 lines, bank 0, attributes off) and the start address resets to 0.
- R2: Width code `ctrl[1:0]` gives 0 → 32 cells (256 pixels), 1 → 40 cells (320 pixels), 2 → 44 cells (352 pixels) and 3 → 32 cells. Any pixel with `pix_x` at or beyond the active width is the border index 8.
- R3: With `ctrl[2]`=0, cells are 12 lines high: row = y/12 and line-in-cell = y mod 12. With `ctrl[2]`=1, cells are 8 lines high: row = y/8 and line-in-cell = y mod 8.
- R4: With `ctrl[3]`=0 the active height is 192 lines, and with `ctrl[3]`=1 it is 240 lines. Any line with `line_y` at or beyond the active height is the border index 8.
- R5: The video RAM word address is (start + row × cells-per-line + `pix_x`/8) mod 2^16. The character is `vram_rdata[7:0]` and the attribute is `vram_rdata[15:8]`.
- R6: The glyph byte is read from font entry bank × 3072 + char × 12 + line-in-cell, where bank is `ctrl[4]`. Writing to the font port (`font_waddr`, `font_wdata`, `font_we`) sets that entry. In 8-line mode only lines 0 to 7 of each glyph are shown.
- R7: Pixel column p (0 to 7) of a cell shows glyph bit 7−p. The glyph is loaded when p = 0 and shifted once per pixel clock.
- R8: With `ctrl[5]`=0, a set glyph bit gives index 7 and a clear bit gives index 0. The attribute byte is ignored.
- R9: With `ctrl[5]`=1, a set glyph bit gives index attribute[2:0] (0 black, 1 red, 2 green, 3 yellow, 4 blue, 5 magenta, 6 cyan, 7 white) and a clear bit gives 0. Attribute bits 7 to 3 are ignored.
- R10: `vram_addr` follows the counters presented one edge earlier, and video RAM returns the word on the next edge. `pix_idx` reflects the counters presented four edges earlier.
- R11: With `reg_we`=1, `reg_sel`=0 loads the start address from `reg_wdata`. `reg_sel`=1 loads the control word from `reg_wdata[5:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects start address, 1 selects control word |
| reg_wdata | input | 16 | Register write data |
| font_we | input | 1 | Font write strobe |
| font_waddr | input | 13 | Font entry to write |
| font_wdata | input | 8 | Glyph row data |
| pix_x | input | 10 | Pixel count within the line |
| line_y | input | 9 | Line count within the frame |
| vram_addr | output | 16 | Video RAM word address |
| vram_rdata | input | 16 | Video RAM word, one edge after the address |
| pix_idx | output | 4 | Palette colour index |

## Verification
The assertions assume that `pix_x` advances by one per clock from a multiple of 8 whenever pixels are being judged, so that the shifter reloads at every cell boundary. They also assume that video RAM answers with exactly one edge of latency, and that the control word and start address are not rewritten while a line is in flight. The bench drives every scan as a contiguous run starting at a cell boundary. Its video RAM model is a registered read. All register writes happen before a scan begins, and each scan flushes the four-stage pipeline before its first comparison.

// File: rtl/atg_pkg.sv
package atg_pkg;

    localparam int VA_W         = 16;
    localparam int XW           = 10;
    localparam int YW           = 9;
    localparam int CI_W         = 4;
    localparam int CELL_H_TALL  = 12;
    localparam int CELL_H_SHORT = 8;
    localparam int N_CHARS      = 256;
    localparam int N_BANKS      = 2;
    localparam int BANK_SPAN    = N_CHARS * CELL_H_TALL;
    localparam int FONT_DEPTH   = N_BANKS * BANK_SPAN;
    localparam int FA_W         = $clog2(FONT_DEPTH);
    localparam int CTRL_W       = 6;

    localparam logic [CI_W-1:0] IDX_BLACK = 4'd0;
    localparam logic [CI_W-1:0] IDX_WHITE = 4'd7;

    typedef enum logic [1:0] {
        WID_32  = 2'd0,
        WID_40  = 2'd1,
        WID_44  = 2'd2,
        WID_RSV = 2'd3
    } width_mode_e;

    typedef struct packed {
        logic        attr_en;
        logic        bank;
        logic        tall;
        logic        cell8;
        width_mode_e wmode;
    } ctrl_t;

    typedef struct packed {
        logic       act;
        logic [2:0] px;
        logic [3:0] lic;
        logic       bank;
        logic       attr_en;
    } meta_t;

    function automatic logic [6:0] cols_of(width_mode_e m);
        case (m)
            WID_40:  return 7'd40;
            WID_44:  return 7'd44;
            default: return 7'd32;
        endcase
    endfunction

    function automatic logic [YW-1:0] lines_of(logic tall);
        return tall ? YW'(240) : YW'(192);
    endfunction

    function automatic logic [3:0] height_of(logic cell8);
        return cell8 ? 4'(CELL_H_SHORT) : 4'(CELL_H_TALL);
    endfunction

    function automatic logic [5:0] rows_of(logic tall, logic cell8);
        case ({tall, cell8})
            2'b00:   return 6'd16;
            2'b01:   return 6'd24;
            2'b10:   return 6'd20;
            default: return 6'd30;
        endcase
    endfunction

    function automatic logic [FA_W-1:0] font_index(logic bank, logic [7:0] ch,
                                                    logic [3:0] lic);
        return FA_W'(bank) * FA_W'(BANK_SPAN)
             + FA_W'(ch) * FA_W'(CELL_H_TALL)
             + FA_W'(lic);
    endfunction

endpackage

// File: rtl/atg_regs.sv
module atg_regs
    import atg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic            sel,
    input  logic [15:0]     wdata,
    output logic [VA_W-1:0] start_o,
    output ctrl_t           ctrl_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_o <= '0;
            ctrl_o  <= '0;
        end else if (we) begin
            if (sel) ctrl_o  <= ctrl_t'(wdata[CTRL_W-1:0]);
            else     start_o <= VA_W'(wdata);
        end
    end

endmodule

// File: rtl/atg_fetch.sv
module atg_fetch
    import atg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [XW-1:0]   x_i,
    input  logic [YW-1:0]   y_i,
    input  logic [VA_W-1:0] start_i,
    input  ctrl_t           ctrl_i,
    output logic [VA_W-1:0] vaddr_o,
    output meta_t           meta_o
);

    logic [6:0]      cols;
    logic [XW-1:0]   width_px;
    logic [YW-1:0]   row;
    logic [3:0]      lic;
    logic            act;
    logic [VA_W-1:0] nxt_addr;

    always_comb begin
        cols     = cols_of(ctrl_i.wmode);
        width_px = XW'({cols, 3'b000});
        act      = (x_i < width_px) && (y_i < lines_of(ctrl_i.tall));
        if (ctrl_i.cell8) begin
            row = y_i >> 3;
            lic = 4'(y_i[2:0]);
        end else begin
            row = y_i / YW'(CELL_H_TALL);
            lic = 4'(y_i % YW'(CELL_H_TALL));
        end
        nxt_addr = start_i + VA_W'(row) * VA_W'(cols) + VA_W'(x_i >> 3);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vaddr_o <= '0;
            meta_o  <= '0;
        end else begin
            vaddr_o        <= nxt_addr;
            meta_o.act     <= act;
            meta_o.px      <= x_i[2:0];
            meta_o.lic     <= lic;
            meta_o.bank    <= ctrl_i.bank;
            meta_o.attr_en <= ctrl_i.attr_en;
        end
    end

    // R5: an active cell's word lies inside the screen window from the start address
    a_r5_addr_in_window: assert property (@(posedge clk) disable iff (rst)
        meta_o.act |-> (VA_W'(vaddr_o - $past(start_i)) <
                        VA_W'(cols_of($past(ctrl_i.wmode))) *
                        VA_W'(rows_of($past(ctrl_i.tall), $past(ctrl_i.cell8)))));

    // R3: line-in-cell stays below the selected cell height
    a_r3_lic_below_height: assert property (@(posedge clk) disable iff (rst)
        meta_o.act |-> (meta_o.lic < height_of($past(ctrl_i.cell8))));

    // R4: an active pixel came from a line inside the selected active height
    a_r4_line_in_area: assert property (@(posedge clk) disable iff (rst)
        meta_o.act |-> ($past(y_i) < lines_of($past(ctrl_i.tall))));

endmodule

// File: rtl/atg_font.sv
module atg_font
    import atg_pkg::*;
(
    input  logic            clk,
    input  logic            we,
    input  logic [FA_W-1:0] waddr,
    input  logic [7:0]      wdata,
    input  logic [FA_W-1:0] raddr,
    output logic [7:0]      rdata
);

    logic [7:0] mem [FONT_DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < FONT_DEPTH)) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/atg_pixel.sv
module atg_pixel
    import atg_pkg::*;
#(
    parameter logic [CI_W-1:0] BORDER_IDX = 4'd8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            act_i,
    input  logic [2:0]      px_i,
    input  logic            attr_en_i,
    input  logic [2:0]      fg_code_i,
    input  logic [7:0]      glyph_i,
    output logic [CI_W-1:0] pix_o
);

    logic [7:0]      sh_q;
    logic [7:0]      sh_nxt;
    logic [CI_W-1:0] fg;

    always_comb begin
        sh_nxt = (px_i == 3'd0) ? glyph_i : {sh_q[6:0], 1'b0};
        fg     = attr_en_i ? CI_W'(fg_code_i) : IDX_WHITE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            pix_o <= BORDER_IDX;
        end else begin
            sh_q <= sh_nxt;
            if (!act_i)         pix_o <= BORDER_IDX;
            else if (sh_nxt[7]) pix_o <= fg;
            else                pix_o <= IDX_BLACK;
        end
    end

    // R1: reset leaves the border index on the output
    a_r1_reset_border: assert property (@(posedge clk)
        rst |=> (pix_o == BORDER_IDX));

    // R8: without attributes only white or black reach the palette
    a_r8_plain_pair: assert property (@(posedge clk) disable iff (rst)
        (act_i && !attr_en_i) |=> (pix_o == IDX_WHITE || pix_o == IDX_BLACK));

endmodule

// File: rtl/atg_text_gen.sv
module atg_text_gen
    import atg_pkg::*;
#(
    parameter logic [CI_W-1:0] BORDER_IDX = 4'd8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic            reg_sel,
    input  logic [15:0]     reg_wdata,
    input  logic            font_we,
    input  logic [FA_W-1:0] font_waddr,
    input  logic [7:0]      font_wdata,
    input  logic [XW-1:0]   pix_x,
    input  logic [YW-1:0]   line_y,
    output logic [VA_W-1:0] vram_addr,
    input  logic [15:0]     vram_rdata,
    output logic [CI_W-1:0] pix_idx
);

    logic [VA_W-1:0] start_q;
    ctrl_t           ctrl_q;
    meta_t           meta1;
    meta_t           meta2;
    logic            act3;
    logic [2:0]      px3;
    logic            attr_en3;
    logic [2:0]      fg3;
    logic [7:0]      glyph3;
    logic            unused_attr_hi;

    assign unused_attr_hi = ^vram_rdata[15:11];

    atg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .sel     (reg_sel),
        .wdata   (reg_wdata),
        .start_o (start_q),
        .ctrl_o  (ctrl_q)
    );

    atg_fetch u_fetch (
        .clk     (clk),
        .rst     (rst),
        .x_i     (pix_x),
        .y_i     (line_y),
        .start_i (start_q),
        .ctrl_i  (ctrl_q),
        .vaddr_o (vram_addr),
        .meta_o  (meta1)
    );

    // stage 2: wait alongside the video RAM read
    always_ff @(posedge clk) begin
        if (rst) meta2 <= '0;
        else     meta2 <= meta1;
    end

    atg_font u_font (
        .clk   (clk),
        .we    (font_we),
        .waddr (font_waddr),
        .wdata (font_wdata),
        .raddr (font_index(meta2.bank, vram_rdata[7:0], meta2.lic)),
        .rdata (glyph3)
    );

    // stage 3: wait alongside the font read
    always_ff @(posedge clk) begin
        if (rst) begin
            act3     <= 1'b0;
            px3      <= '0;
            attr_en3 <= 1'b0;
            fg3      <= '0;
        end else begin
            act3     <= meta2.act;
            px3      <= meta2.px;
            attr_en3 <= meta2.attr_en;
            fg3      <= vram_rdata[10:8];
        end
    end

    atg_pixel #(.BORDER_IDX(BORDER_IDX)) u_pixel (
        .clk       (clk),
        .rst       (rst),
        .act_i     (act3),
        .px_i      (px3),
        .attr_en_i (attr_en3),
        .fg_code_i (fg3),
        .glyph_i   (glyph3),
        .pix_o     (pix_idx)
    );

endmodule

// File: tb/sim_atg_text_gen.sv
module sim_atg_text_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        font_we = 1'b0;
    logic [12:0] font_waddr = '0;
    logic [7:0]  font_wdata = '0;
    logic [9:0]  pix_x = '0;
    logic [8:0]  line_y = '0;
    logic [15:0] vram_addr;
    logic [15:0] vram_rdata = '0;
    logic [3:0]  pix_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [15:0] mem [0:4095];

    always #4 clk = ~clk;

    always @(posedge clk) vram_rdata <= mem[vram_addr[11:0]];

    atg_text_gen u0 (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .font_we    (font_we),
        .font_waddr (font_waddr),
        .font_wdata (font_wdata),
        .pix_x      (pix_x),
        .line_y     (line_y),
        .vram_addr  (vram_addr),
        .vram_rdata (vram_rdata),
        .pix_idx    (pix_idx)
    );

    function automatic logic [7:0] glyph(int b, int ch, int r);
        return 8'(ch * 3 + r * 29 + b * 91) ^ 8'(r);
    endfunction

    function automatic int exp_pix(int x, int y, logic [5:0] ctrl, int start);
        int cols, h, lines, row, lic, addr;
        logic [15:0] w;
        logic [7:0]  g;
        cols  = (ctrl[1:0] == 2'd1) ? 40 : (ctrl[1:0] == 2'd2) ? 44 : 32;
        h     = ctrl[2] ? 8 : 12;
        lines = ctrl[3] ? 240 : 192;
        if (x >= cols * 8 || y >= lines) return 8;
        row  = y / h;
        lic  = y % h;
        addr = (start + row * cols + x / 8) & 16'hFFFF;
        w    = mem[addr & 12'hFFF];
        g    = glyph(int'(ctrl[4]), int'(w[7:0]), lic);
        if (!g[7 - (x % 8)]) return 0;
        return ctrl[5] ? int'(w[10:8]) : 7;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_reg(logic sel, logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic scan(logic [5:0] ctrl, int start, int y, int n, string tag);
        int e [0:511];
        wr_reg(1'b0, 16'(start));
        wr_reg(1'b1, 16'(ctrl));
        for (int j = 0; j < n + 4; j++) begin
            @(negedge clk);
            if (j >= 4) chk(tag, int'(pix_idx), e[j - 4]);
            if (j < n) begin
                pix_x  = 10'(j);
                line_y = 9'(y);
                e[j]   = exp_pix(j, y, ctrl, start);
            end
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset index", int'(pix_idx), 8);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 first edge after reset", int'(pix_idx), 8);
        // default control: 32 cells, white on black, attribute byte ignored
        scan(6'b000000, 0, 5, 272, "R1 R2 R7 R8");
    endtask

    task automatic t_widths;
        scan(6'b000001, 16'h0100, 30, 336, "R2 R11 width 40");
        scan(6'b000010, 16'h0200, 77, 368, "R2 width 44");
        scan(6'b000011, 16'h0000, 13, 264, "R2 reserved width");
    endtask

    task automatic t_cells;
        scan(6'b000100, 0, 100, 264, "R3 R6 short cell");
        scan(6'b000100, 0, 191, 264, "R3 last short row");
        scan(6'b000000, 0, 191, 264, "R3 last tall row");
    endtask

    task automatic t_height;
        scan(6'b001000, 0, 230, 264, "R4 tall area");
        scan(6'b000000, 0, 230, 40, "R4 beyond short area");
        scan(6'b001100, 0, 239, 264, "R4 last line");
        scan(6'b001000, 0, 240, 16, "R4 beyond tall area");
    endtask

    task automatic t_attr;
        scan(6'b100010, 16'h0040, 50, 360, "R9 attributes");
        scan(6'b110001, 16'h0300, 144, 328, "R9 R6 attributes bank1");
    endtask

    task automatic t_bank;
        scan(6'b010000, 0, 17, 264, "R6 bank1");
    endtask

    task automatic t_wrap;
        scan(6'b000001, 16'hFFF0, 120, 328, "R5 address wrap");
    endtask

    task automatic t_addr;
        wr_reg(1'b0, 16'h1234);
        wr_reg(1'b1, 16'h0002);
        @(negedge clk);
        pix_x = 10'd83; line_y = 9'd27;
        @(negedge clk);
        chk("R5 R10 word address", int'(vram_addr), 16'h1296);
        pix_x = 10'd8; line_y = 9'd8;
        wr_reg(1'b1, 16'h0004);
        @(negedge clk);
        chk("R3 R5 short cell address", int'(vram_addr), 16'h1234 + 32 + 1);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = {8'(i * 7 + 3), 8'(i * 13 + 1)};
        for (int a = 0; a < 6144; a++) begin
            @(negedge clk);
            font_we    = 1'b1;
            font_waddr = 13'(a);
            font_wdata = glyph(a / 3072, (a % 3072) / 12, a % 12);
        end
        @(negedge clk);
        font_we = 1'b0;
        t_reset();
        t_widths();
        t_cells();
        t_height();
        t_attr();
        t_bank();
        t_wrap();
        t_addr();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule